// File: doc/BRIEF.md
# 64-bit Integer Add/Subtract Unit with Carry and Overflow Flags

This block is the adder lane of an integer execution pipeline. Each accepted request has these inputs:

- two register operands;
- a 16-bit immediate;
- an operation code;
- the current carry, overflow and summary-overflow status bits.

From them the block forms one sum and derives the status bits at two widths, 64 bits and 32 bits. It also forms an optional three-way sign/zero compare nibble. The status inputs come from the architectural status register. The status outputs are written back to it. When those bits must not change, the block passes them through unchanged.

The arithmetic is a single combinational pass: an operand selector feeds a split carry adder, and flag logic follows the adder. One register stage sits on the output. A request presented with `in_valid` high returns its results on the next clock edge, marked by `out_valid`. Register-file reads and instruction decode stay outside the block. The caller supplies a flag that says the A register field was zero, the "overflow enable" flag and the "record" flag.

Top module: `addsub_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `cr_wr`, `result`, `carry_out`, `ovf_out`, `so_out` and `cr_out` are all zero.
- R2: A request sampled with `in_valid` high on a rising edge has its results on the outputs, with `out_valid` high, from that edge until the next accepted request. `out_valid` is low after any edge where `in_valid` was low.
- R3: Op 0 (add) returns A+B. Op 1 (subtract-from) returns ~A+B+1. Both leave `carry_out` equal to `carry_in`.
- R4: Four ops use `carry_in[0]` as the carry-in and write both carry bits:
  - op 2 (add-extended) returns A+B+c;
  - op 3 (add-minus-one) returns A+c+0xFFFF_FFFF_FFFF_FFFF;
  - op 4 (subtract-from-minus-one) returns ~A+c+0xFFFF_FFFF_FFFF_FFFF;
  - op 5 (add-to-zero) returns A+c.
- R5: In every carry-writing op, `carry_out[0]` is the carry out of bit 63 of the full sum. `carry_out[1]` is the carry out of bit 31 of the sum of the low 32-bit halves, with the same carry-in.
- R6: With `ovf_en` high (all ops except 9), `ovf_out[0]` and `ovf_out[1]` are (carry XOR result MSB) AND NOT (x MSB XOR y MSB). Here x and y are the two addends after inversion, and the two bits are taken at bit 63 and at bit 31. With `ovf_en` low, `ovf_out` equals `ovf_in`.
- R7: `so_out` is `so_in` OR (`ovf_en` AND the new 64-bit overflow). It is never cleared by any op.
- R8: Op 6 returns A' + sign-extended immediate. Op 7 returns A' + (sign-extended immediate shifted left by 16). In both, A' is zero when `a_is_zero` is high and A otherwise. Neither op changes the carry bits.
- R9: Op 8 (subtract-from-immediate) returns ~A + sign-extended immediate + 1 and writes both carry bits.
- R10: Op 9 (extended add through overflow) has these effects:
  - it returns A+B+`ovf_in[0]`;
  - it writes the bit-63 carry into `ovf_out[0]` and the bit-31 carry into `ovf_out[1]`;
  - it leaves `carry_out` and `so_out` equal to their inputs, whatever `ovf_en` is.
- R11: When `record` was high with the request, `cr_wr` is high and `cr_out` is {lt, gt, eq, so} from bit 3 down to bit 0:
  - lt is result bit 63;
  - eq means the result is zero;
  - gt means neither lt nor eq;
  - so is the new `so_out`.

  Otherwise `cr_wr` is low.
- R12: Op codes 10 to 15 behave exactly as op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| imm | input | 16 | Immediate, sign-extended inside |
| a_is_zero | input | 1 | A register field is zero (ops 6 and 7 use literal zero) |
| ovf_en | input | 1 | Overflow-enabled variant |
| record | input | 1 | Produce the compare nibble |
| carry_in | input | 2 | Incoming {carry32, carry} |
| ovf_in | input | 2 | Incoming {ov32, ov} |
| so_in | input | 1 | Incoming summary overflow |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Sum |
| carry_out | output | 2 | New {carry32, carry} |
| ovf_out | output | 2 | New {ov32, ov} |
| so_out | output | 1 | New summary overflow |
| cr_out | output | 4 | Compare nibble {lt, gt, eq, so} |
| cr_wr | output | 1 | Compare nibble is meaningful |

## Verification
The operands are drawn from two pools: uniformly random 64-bit values, and edge values such as zero, all-ones, the largest positive number and the most negative number, with low halves near 0x7FFF_FFFF and 0x8000_0000.

- Random values show the ordinary sum path.
- The edge values separate the bit-31 carry and overflow from the bit-63 ones, and show where the carry-in ripples through a full width.

Directed cases cover further distinctions:

- the all-ones addend with and without carry-in;
- literal-zero versus register A for the immediate ops;
- a set summary-overflow bit that must survive a non-overflowing op;
- the overflow-chained add, which must touch only the overflow bits.

Reserved op codes are mixed into the random stream and must match plain add.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUBF   = 4'd1,
    OP_ADDE   = 4'd2,
    OP_ADDME  = 4'd3,
    OP_SUBFME = 4'd4,
    OP_ADDZE  = 4'd5,
    OP_ADDI   = 4'd6,
    OP_ADDIS  = 4'd7,
    OP_SUBFIC = 4'd8,
    OP_ADDEX  = 4'd9
  } op_e;
endpackage

// File: rtl/addsub_operands.sv
module addsub_operands
  import addsub_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [IMM_W-1:0] imm,
  input  logic         a_is_zero,
  input  logic         ca_bit,
  input  logic         ov_bit,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         cin,
  output logic         wr_carry,
  output logic         ov_chain
);
  localparam int EXT_W = W - IMM_W;
  localparam int HI_W  = W - 2 * IMM_W;

  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_hi;
  logic [W-1:0] a_or_zero;

  assign imm_sx    = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_hi    = {{HI_W{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
  assign a_or_zero = a_is_zero ? '0 : opa;

  always_comb begin
    x        = opa;
    y        = opb;
    cin      = 1'b0;
    wr_carry = 1'b0;
    ov_chain = 1'b0;
    case (op_e'(op))
      OP_SUBF:   begin x = ~opa; cin = 1'b1; end
      OP_ADDE:   begin cin = ca_bit; wr_carry = 1'b1; end
      OP_ADDME:  begin y = '1; cin = ca_bit; wr_carry = 1'b1; end
      OP_SUBFME: begin x = ~opa; y = '1; cin = ca_bit; wr_carry = 1'b1; end
      OP_ADDZE:  begin y = '0; cin = ca_bit; wr_carry = 1'b1; end
      OP_ADDI:   begin x = a_or_zero; y = imm_sx; end
      OP_ADDIS:  begin x = a_or_zero; y = imm_hi; end
      OP_SUBFIC: begin x = ~opa; y = imm_sx; cin = 1'b1; wr_carry = 1'b1; end
      OP_ADDEX:  begin cin = ov_bit; ov_chain = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W    = 64,
  parameter int LO_W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_hi,
  output logic         co_lo,
  output logic         ov_hi,
  output logic         ov_lo
);
  localparam int HI_W = W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  assign lo_sum = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
  assign hi_sum = {1'b0, x[W-1:LO_W]} + {1'b0, y[W-1:LO_W]} + {{HI_W{1'b0}}, lo_sum[LO_W]};

  assign sum   = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign co_lo = lo_sum[LO_W];
  assign co_hi = hi_sum[HI_W];
  assign ov_hi = (co_hi ^ sum[W-1])    & ~(x[W-1]    ^ y[W-1]);
  assign ov_lo = (co_lo ^ sum[LO_W-1]) & ~(x[LO_W-1] ^ y[LO_W-1]);
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W     = 64,
  parameter int LO_W  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             a_is_zero,
  input  logic             ovf_en,
  input  logic             record,
  input  logic [1:0]       carry_in,
  input  logic [1:0]       ovf_in,
  input  logic             so_in,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic [1:0]       carry_out,
  output logic [1:0]       ovf_out,
  output logic             so_out,
  output logic [3:0]       cr_out,
  output logic             cr_wr
);
  logic [W-1:0] x, y, sum;
  logic         cin, wr_carry, ov_chain;
  logic         co_hi, co_lo, ov_hi, ov_lo;
  logic [1:0]   carry_nx, ovf_nx;
  logic         so_nx;
  logic [3:0]   cr_nx;

  addsub_operands #(.W(W), .IMM_W(IMM_W)) u_sel (
    .op(op), .opa(opa), .opb(opb), .imm(imm), .a_is_zero(a_is_zero),
    .ca_bit(carry_in[0]), .ov_bit(ovf_in[0]),
    .x(x), .y(y), .cin(cin), .wr_carry(wr_carry), .ov_chain(ov_chain)
  );

  addsub_core #(.W(W), .LO_W(LO_W)) u_core (
    .x(x), .y(y), .cin(cin), .sum(sum),
    .co_hi(co_hi), .co_lo(co_lo), .ov_hi(ov_hi), .ov_lo(ov_lo)
  );

  always_comb begin
    carry_nx = wr_carry ? {co_lo, co_hi} : carry_in;
    ovf_nx   = ovf_in;
    so_nx    = so_in;
    if (ov_chain) begin
      ovf_nx = {co_lo, co_hi};
    end else if (ovf_en) begin
      ovf_nx = {ov_lo, ov_hi};
      so_nx  = so_in | ov_hi;
    end
    cr_nx = {sum[W-1], ~sum[W-1] & (|sum), ~(|sum), so_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cr_wr     <= 1'b0;
      result    <= '0;
      carry_out <= '0;
      ovf_out   <= '0;
      so_out    <= 1'b0;
      cr_out    <= '0;
    end else begin
      out_valid <= in_valid;
      cr_wr     <= in_valid & record;
      if (in_valid) begin
        result    <= sum;
        carry_out <= carry_nx;
        ovf_out   <= ovf_nx;
        so_out    <= so_nx;
        cr_out    <= record ? cr_nx : 4'd0;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_carry_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_ADD || op == OP_SUBF)) |=> (carry_out == $past(carry_in)));

  p_so_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && so_in) |=> so_out);

  p_ovchain_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADDEX) |=> (carry_out == $past(carry_in) && so_out == $past(so_in)));

  p_cr_form_r11: assert property (@(posedge clk) disable iff (rst)
    cr_wr |-> (cr_out[0] == so_out && $countones(cr_out[3:1]) == 1));
endmodule

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] opa, opb;
  logic [15:0] imm;
  logic        a_is_zero, ovf_en, record;
  logic [1:0]  carry_in, ovf_in;
  logic        so_in;
  logic        out_valid;
  logic [63:0] result;
  logic [1:0]  carry_out, ovf_out;
  logic        so_out;
  logic [3:0]  cr_out;
  logic        cr_wr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .imm(imm), .a_is_zero(a_is_zero), .ovf_en(ovf_en), .record(record),
    .carry_in(carry_in), .ovf_in(ovf_in), .so_in(so_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .ovf_out(ovf_out), .so_out(so_out), .cr_out(cr_out), .cr_wr(cr_wr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im, input logic az, input logic oe,
                       input logic [1:0] ci, input logic [1:0] vi, input logic si,
                       output logic [63:0] r, output logic [1:0] co,
                       output logic [1:0] vo, output logic so, output logic [3:0] cr);
    logic [63:0] x, y, sx;
    logic        c, wc, ex;
    logic [64:0] s;
    logic [32:0] s32;
    logic        ov, ov32;
    sx = {{48{im[15]}}, im};
    x = a; y = b; c = 1'b0; wc = 1'b0; ex = 1'b0;
    case (o)
      4'd1: begin x = ~a; c = 1'b1; end
      4'd2: begin c = ci[0]; wc = 1'b1; end
      4'd3: begin y = '1; c = ci[0]; wc = 1'b1; end
      4'd4: begin x = ~a; y = '1; c = ci[0]; wc = 1'b1; end
      4'd5: begin y = '0; c = ci[0]; wc = 1'b1; end
      4'd6: begin x = az ? 64'd0 : a; y = sx; end
      4'd7: begin x = az ? 64'd0 : a; y = sx << 16; end
      4'd8: begin x = ~a; y = sx; c = 1'b1; wc = 1'b1; end
      4'd9: begin c = vi[0]; ex = 1'b1; end
      default: ;
    endcase
    s    = {1'b0, x} + {1'b0, y} + {64'd0, c};
    s32  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, c};
    r    = s[63:0];
    ov   = (s[64] ^ s[63]) & ~(x[63] ^ y[63]);
    ov32 = (s32[32] ^ s[31]) & ~(x[31] ^ y[31]);
    co   = wc ? {s32[32], s[64]} : ci;
    vo = vi; so = si;
    if (ex) vo = {s32[32], s[64]};
    else if (oe) begin vo = {ov32, ov}; so = si | ov; end
    cr = {r[63], !r[63] && r != 0, r == 0, so};
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3, 4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                     input logic [15:0] im, input logic az, input logic oe, input logic rc,
                     input logic [1:0] ci, input logic [1:0] vi, input logic si);
    logic [63:0] er;
    logic [1:0]  eco, evo;
    logic        eso;
    logic [3:0]  ecr;
    model(o, a, b, im, az, oe, ci, vi, si, er, eco, evo, eso, ecr);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; imm = im; a_is_zero = az;
    ovf_en = oe; record = rc; carry_in = ci; ovf_in = vi; so_in = si;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2", "out_valid", 64'(out_valid), 64'd1);
    check(result == er, req_of(o), "result", result, er);
    check(carry_out == eco, (o == 4'd9) ? "R10" : "R5", "carry", 64'(carry_out), 64'(eco));
    check(ovf_out == evo, (o == 4'd9) ? "R10" : "R6", "ovf", 64'(ovf_out), 64'(evo));
    check(so_out == eso, "R7", "so", 64'(so_out), 64'(eso));
    check(cr_wr == rc, "R11", "cr_wr", 64'(cr_wr), 64'(rc));
    if (rc) check(cr_out == ecr, "R11", "cr", 64'(cr_out), 64'(ecr));
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return {$urandom, $urandom};
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return {$urandom, 32'h7FFF_FFFF};
      default: return {$urandom, 32'h8000_0000 | ($urandom % 2)};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst = 1'b1; in_valid = 1'b0; op = '0; opa = '0; opb = '0; imm = '0;
    a_is_zero = 1'b0; ovf_en = 1'b0; record = 1'b0; carry_in = '0; ovf_in = '0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && cr_wr == 1'b0, "R1", "strobes", 64'({out_valid, cr_wr}), 64'd0);
    check(result == 64'd0 && carry_out == 2'd0 && ovf_out == 2'd0 && so_out == 1'b0 && cr_out == 4'd0,
          "R1", "outputs", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "after reset", 64'(out_valid), 64'd0);

    // R4: add-minus-one without and with carry-in
    run(4'd3, 64'h7_FFFF_FFFF, 64'd0, 16'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0);
    run(4'd3, 64'h7_FFFF_FFFF, 64'd0, 16'd0, 1'b0, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0);
    run(4'd4, 64'd0, 64'd0, 16'd0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0);
    run(4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, 1'b0, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0);
    // R8: literal zero versus register A
    run(4'd7, 64'd5, 64'd0, 16'd1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0);
    run(4'd7, 64'd5, 64'd0, 16'd1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0);
    run(4'd6, 64'd5, 64'd0, 16'h8000, 1'b1, 1'b0, 1'b0, 2'b11, 2'b00, 1'b0);
    // R9: subtract-from-immediate
    run(4'd8, 64'd3, 64'd0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0);
    // R7: sticky SO on a non-overflowing op; R6: overflow-enabled signed overflow
    run(4'd0, 64'd1, 64'd2, 16'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1);
    run(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00, 1'b0);
    run(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b0, 1'b0, 1'b0, 2'b10, 2'b11, 1'b0);
    // R10: extended add through overflow
    run(4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b01, 1'b0);
    run(4'd9, 64'h0000_0000_FFFF_FFFF, 64'd0, 16'd0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b01, 1'b1);
    // R12: reserved code
    run(4'd13, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'd0, 1'b0, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0);

    // R2: strobe drops after an idle cycle
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "idle out_valid", 64'(out_valid), 64'd0);

    for (int i = 0; i < 400; i++) begin
      run(4'($urandom % 12), pick(), pick(), 16'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule